// File: doc/BRIEF.md
# DRAM Mode-Register-0 DLL Reset Tracker

This block sits inside a memory controller beside the command scheduler. It keeps a shadow copy of the first mode register of a DDR-style SDRAM. It captures every write to that register, decodes the write-recovery field into a cycle count, and presents the DLL-reset request bit as self-clearing, so that bit always reads back as zero.

When a write asks for a DLL reset, the block opens a lock window of a fixed number of clock cycles (512 by default). While the window is open, READ requests are refused. Once it closes, a request is granted in the same cycle it is raised. Clock-enable must stay high for the whole window. A low clock-enable inside the window, or a write that selects the reserved write-recovery code, raises a sticky error flag that stays set until reset.

The asynchronous active-low reset is released through a two-stage synchronizer. Outputs settle two clock edges after reset is deasserted.

Top module: `dll_mr0_tracker`

## Requirements
- R1: After reset the register readback is all zeros, the write-recovery output is 16, the error flag is 0 and no lock window is open, so the read grant follows the read request.
- R2: A write strobe stores the 13-bit value at the clock edge. From the next cycle the readback equals the written value with bit 8 forced to 0.
- R3: A write with bit 8 set opens a lock window. The read grant is held low for exactly LOCK_CYCLES cycles after the write edge, even with the request high, and is granted in the cycle after that.
- R4: With no window open, the read grant equals the read request in the same cycle, with no register in the path.
- R5: A write with bit 8 set while a window is open restarts the full LOCK_CYCLES count from that write edge.
- R6: Write-recovery field bits 11:9 decode as follows: 001 gives 5, 010 gives 6, 011 gives 7, 100 gives 8, 101 gives 10, 110 gives 12 and 000 gives 16 cycles.
- R7: Field code 111 drives the write-recovery output to 0 and sets the error flag from the cycle after the write.
- R8: Clock-enable low at any clock edge inside a lock window sets the error flag from the next cycle. Clock-enable low outside a window leaves the flag at 0. Once set, the flag stays set until reset.
- R9: A write with bit 8 clear during an open window neither closes it nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_wr_en | input | 1 | Mode-register write strobe |
| mr_wr_data | input | 13 | Value written to the mode register |
| cke | input | 1 | Clock-enable level driven to the memory |
| rd_req | input | 1 | READ command request from the scheduler |
| rd_grant | output | 1 | READ command permitted this cycle |
| wr_rec_cycles | output | 5 | Decoded write-recovery cycle count (0 for the reserved code) |
| mr_rdata | output | 13 | Shadow register readback, bit 8 always 0 |
| err_flag | output | 1 | Sticky error: clock-enable low during the window or reserved code |

## Verification
The bench builds the block with its default values: a 13-bit register and a lock window of 512 cycles. The blocked interval is checked cycle by cycle over its full length, including the first granted cycle exactly 512 cycles after the reset write. This keeps the real off-by-one boundary of the lock count within reach, together with a restart in mid-window and clock-enable drops on both sides of the window's closing edge.

// File: rtl/dll_mr0_pkg.sv
package dll_mr0_pkg;

  localparam int MR_W       = 13;
  localparam int DLL_BIT    = 8;
  localparam int WR_LSB     = 9;
  localparam int WR_CODE_W  = 3;
  localparam int WR_CYC_W   = 5;

  typedef logic [WR_CODE_W-1:0] wr_code_t;
  typedef logic [WR_CYC_W-1:0]  wr_cyc_t;

  localparam wr_code_t WR_CODE_BAD = 3'b111;

  function automatic wr_cyc_t wr_decode(input wr_code_t code);
    wr_cyc_t cyc;
    case (code)
      3'b000:  cyc = 5'd16;
      3'b001:  cyc = 5'd5;
      3'b010:  cyc = 5'd6;
      3'b011:  cyc = 5'd7;
      3'b100:  cyc = 5'd8;
      3'b101:  cyc = 5'd10;
      3'b110:  cyc = 5'd12;
      default: cyc = 5'd0;
    endcase
    return cyc;
  endfunction

endpackage

// File: rtl/mr0_shadow.sv
module mr0_shadow
  import dll_mr0_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [MR_W-1:0] wr_data,
  output logic [MR_W-1:0] rdata,
  output logic            dll_start,
  output logic            code_bad,
  output wr_cyc_t         wr_cycles
);

  logic [MR_W-1:0] mr_q, mr_d;
  wr_code_t        new_code;

  assign new_code = wr_data[WR_LSB +: WR_CODE_W];

  always_comb begin
    mr_d = mr_q;
    if (wr_en) begin
      mr_d          = wr_data;
      mr_d[DLL_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mr_q <= '0;
    else        mr_q <= mr_d;
  end

  assign rdata     = mr_q;
  assign dll_start = wr_en & wr_data[DLL_BIT];
  assign code_bad  = wr_en & (new_code == WR_CODE_BAD);
  assign wr_cycles = wr_decode(mr_q[WR_LSB +: WR_CODE_W]);

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[DLL_BIT] == 1'b0) &&
              (rdata[WR_LSB +: WR_CODE_W] == $past(new_code)));

endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int LOCK_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R3 R5
  window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (cnt_q == LOAD));

  // R3 R9
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> busy);

endmodule

// File: rtl/dll_fault_monitor.sv
module dll_fault_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic window,
  input  logic cke,
  input  logic code_bad,
  output logic err
);

  logic err_q, err_d;

  always_comb begin
    err_d = err_q | (window & ~cke) | code_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  // R8
  cke_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window && !cke) |=> err);

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_bad |=> err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/dll_mr0_tracker.sv
module dll_mr0_tracker
  import dll_mr0_pkg::*;
#(
  parameter int LOCK_CYCLES = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mr_wr_en,
  input  logic [MR_W-1:0] mr_wr_data,
  input  logic            cke,
  input  logic            rd_req,
  output logic            rd_grant,
  output logic [4:0]      wr_rec_cycles,
  output logic [MR_W-1:0] mr_rdata,
  output logic            err_flag
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       dll_start, code_bad, busy;
  wr_cyc_t    wr_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mr0_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (mr_wr_en),
    .wr_data   (mr_wr_data),
    .rdata     (mr_rdata),
    .dll_start (dll_start),
    .code_bad  (code_bad),
    .wr_cycles (wr_cycles)
  );

  dll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (dll_start),
    .busy  (busy)
  );

  dll_fault_monitor u_fault (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .window   (busy),
    .cke      (cke),
    .code_bad (code_bad),
    .err      (err_flag)
  );

  assign rd_grant      = rd_req & ~busy;
  assign wr_rec_cycles = wr_cycles;

  // R3
  no_read_in_window_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(dll_start) |-> !rd_grant);

endmodule

// File: tb/dll_mr0_tracker_tb.sv
module dll_mr0_tracker_tb;

  localparam int LOCK = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mr_wr_en;
  logic [12:0] mr_wr_data;
  logic        cke;
  logic        rd_req;
  logic        rd_grant;
  logic [4:0]  wr_rec_cycles;
  logic [12:0] mr_rdata;
  logic        err_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  dll_mr0_tracker #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .mr_wr_en(mr_wr_en), .mr_wr_data(mr_wr_data),
    .cke(cke), .rd_req(rd_req), .rd_grant(rd_grant),
    .wr_rec_cycles(wr_rec_cycles), .mr_rdata(mr_rdata), .err_flag(err_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mr_wr_en = 1'b0; mr_wr_data = '0; cke = 1'b1; rd_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // write at the next edge; returns at the negedge just after that edge
  task automatic mr_write(input logic [12:0] val);
    mr_wr_en = 1'b1; mr_wr_data = val;
    @(negedge clk);
    mr_wr_en = 1'b0;
  endtask

  // counts blocked cycles starting now, returns number blocked before grant
  task automatic count_blocked(output int n);
    n = 0;
    rd_req = 1'b1;
    while (!rd_grant && n < 4 * LOCK) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rdata", mr_rdata, 0);
    check("R1 wr_rec", wr_rec_cycles, 16);
    check("R1 err", err_flag, 0);
    rd_req = 1'b1; #1;
    check("R1 grant", rd_grant, 1);
    rd_req = 1'b0; #1;
    check("R4 grant low", rd_grant, 0);
    rd_req = 1'b1; #1;
    check("R4 grant same cycle", rd_grant, 1);
    rd_req = 1'b0;
  endtask

  task automatic t_capture();
    do_reset();
    mr_write(13'h1A5A & ~13'h0100);
    check("R2 readback", mr_rdata, 13'h1A5A & ~13'h0100);
    mr_write(13'h0D7F);
    check("R2 bit8 cleared", mr_rdata, 13'h0D7F & ~13'h0100);
  endtask

  task automatic t_decode();
    int exp_tab[7] = '{16, 5, 6, 7, 8, 10, 12};
    do_reset();
    for (int c = 0; c < 7; c++) begin
      mr_write(13'(c << 9));
      check("R6 decode", wr_rec_cycles, exp_tab[c]);
    end
    check("R6 no err", err_flag, 0);
  endtask

  task automatic t_bad_code();
    do_reset();
    mr_write(13'(7 << 9));
    check("R7 wr_rec zero", wr_rec_cycles, 0);
    check("R7 err", err_flag, 1);
    mr_write(13'(1 << 9));
    check("R8 err sticky", err_flag, 1);
  endtask

  task automatic t_window();
    int n;
    do_reset();
    mr_write(13'h0100);
    check("R2 bit8 reads 0", mr_rdata[8], 0);
    count_blocked(n);
    check("R3 blocked cycles", n, LOCK);
    check("R3 grant after window", rd_grant, 1);
    check("R8 no err full window", err_flag, 0);
    rd_req = 1'b0;
  endtask

  task automatic t_restart();
    int n;
    do_reset();
    mr_write(13'h0100);
    repeat (199) @(negedge clk);
    mr_write(13'h0100);
    count_blocked(n);
    check("R5 restart blocked", n, LOCK);
    rd_req = 1'b0;
  endtask

  task automatic t_plain_write_in_window();
    int n;
    do_reset();
    mr_write(13'h0100);
    repeat (99) @(negedge clk);
    mr_write(13'(3 << 9));
    check("R9 field still captured", wr_rec_cycles, 7);
    count_blocked(n);
    check("R9 window unchanged", n, LOCK - 100);
    rd_req = 1'b0;
  endtask

  task automatic t_cke();
    do_reset();
    cke = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 cke low idle", err_flag, 0);
    cke = 1'b1;
    mr_write(13'h0100);
    repeat (LOCK - 1) @(negedge clk);
    // last cycle of window: edge ahead still inside
    check("R3 last blocked cycle", rd_grant, 0);
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    check("R8 cke low at last window edge", err_flag, 1);
    do_reset();
    mr_write(13'h0100);
    repeat (LOCK) @(negedge clk);
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    check("R8 cke low just after window", err_flag, 0);
    mr_write(13'h0100);
    repeat (10) @(negedge clk);
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 cke low mid window sticky", err_flag, 1);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_decode();
    t_bad_code();
    t_window();
    t_restart();
    t_plain_write_in_window();
    t_cke();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule